// File: doc/BRIEF.md
# Default Control Endpoint Transfer Sequencer

This block runs the device-side control flow of endpoint 0 in a USB function controller. It follows a control request through its phases. A setup packet arrives and the local CPU services it. An optional data phase follows, either toward the host (IN) or from the host (OUT). A status handshake closes the request. Data storage, the serial engine and request decoding sit outside the block. The bus side is modelled as single-cycle token strobes from a packet engine. The block answers each token, one cycle later, with a handshake code: ACK, NAK or STALL.

The CPU drives the sequencer through write strobes. One strobe acknowledges the setup packet, one marks a queued IN packet, one flags the last packet, one requests a stall, and one clears the stall report. The CPU reads the flags back as level outputs. The block detects protocol errors on its own. Host data that arrives after the last packet has been flagged, or after a stall has been requested, is refused with STALL. A sticky sent-stall flag and an interrupt report that refusal.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset, all flags and both interrupt outputs are 0, `hs_valid` is 0 and `stage` reads 0. Stage codes: 0 idle, 1 OUT data, 2 IN data, 3 status, 4 stalled.
- R2: A setup token in any stage does the following one cycle later:
  - it answers ACK;
  - it sets `rx_ready`;
  - it clears `tx_ready`, `data_end` and `send_stall`;
  - it returns `stage` to 0;
  - it latches `tok_setup_dir_in` as the direction of the request.
- R3: A CPU write with `cpu_svc` clears `rx_ready`. If that write happens in stage 0 while `rx_ready` is set, the next stage is:
  - 3 if `cpu_dend` is set in the same write;
  - otherwise 2 for an IN request;
  - otherwise 1 for an OUT request.
- R4: In stage 2, an IN token with `tx_ready` set is answered ACK and clears `tx_ready`. The same token with `tx_ready` clear is answered NAK.
- R5: An IN token answered ACK while `data_end` is set moves `stage` to 3.
- R6: In stage 1, an OUT token with `rx_ready` clear is answered ACK and sets `rx_ready`; with `rx_ready` set it is answered NAK. A write of `cpu_svc` together with `cpu_dend` in stage 1 moves `stage` to 3.
- R7: A status token in stage 3 is answered ACK, clears `data_end` and returns `stage` to 0. A status token in stage 0, 1 or 2 is answered NAK.
- R8: A write with `cpu_sstall` sets `send_stall` and moves `stage` to 4. In stage 4, or while `send_stall` is set, any IN, OUT or status token does the following:
  - it is answered STALL;
  - it sets `sent_stall`;
  - it clears `send_stall` and `tx_ready`;
  - it leaves `stage` at 4.
  Only a setup token leaves stage 4.
- R9: An OUT token while `data_end` is set is answered STALL, sets `sent_stall` and moves `stage` to 4.
- R10: `sent_stall` stays set until a CPU write with `cpu_clr_sent` clears it.
- R11: `irq_pulse` is high for one cycle after each token answered ACK or STALL, and never after a NAK. `irq_pending` is set by that event and cleared by `cpu_rd`. The set wins if both happen in the same cycle.
- R12: `hs_valid` is high exactly in the cycle after a token, and `hs_code` carries 1 for ACK, 2 for NAK and 3 for STALL. Any token not covered above is answered NAK.
- R13: A setup token in the same cycle as a CPU write overrides the write entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | Setup packet received |
| tok_setup_dir_in | input | 1 | Request direction with setup (1 = IN) |
| tok_out | input | 1 | OUT data packet received |
| tok_in | input | 1 | IN request from host |
| tok_status | input | 1 | Status-phase token |
| hs_valid | output | 1 | Handshake code valid |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_svc | input | 1 | Setup/packet serviced |
| cpu_txr | input | 1 | IN packet queued |
| cpu_dend | input | 1 | Last packet of data phase |
| cpu_sstall | input | 1 | Request stall |
| cpu_clr_sent | input | 1 | Clear sent-stall (write one to clear) |
| cpu_rd | input | 1 | CPU status read, clears pending interrupt |
| rx_ready | output | 1 | Received packet waiting for CPU |
| tx_ready | output | 1 | IN packet waiting for host |
| data_end | output | 1 | Last packet flagged |
| send_stall | output | 1 | Stall requested, not yet issued |
| sent_stall | output | 1 | Stall has been issued (sticky) |
| stage | output | 3 | Current transfer stage |
| irq_pulse | output | 1 | One-cycle interrupt event |
| irq_pending | output | 1 | Sticky interrupt pending |

## Verification
A wrong stage or a wrong flag shows up on `hs_code` at the first token that depends on it, one cycle after that token. The usual symptom is NAK where ACK was due, or a missing STALL. `stage` and the flag outputs show the error one cycle after the event that caused it. A reference model in the bench is compared against every output on every cycle of random token and write traffic. Any divergence is therefore caught in the cycle where it first appears.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int ST_W = 3;
  localparam int HS_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_RX      = 3'd1,
    ST_TX      = 3'd2,
    ST_STATUS  = 3'd3,
    ST_STALLED = 3'd4
  } ep0_stage_t;

  typedef enum logic [HS_W-1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } ep0_hs_t;

  typedef struct packed {
    logic rx_ready;
    logic tx_ready;
    logic data_end;
    logic send_stall;
    logic sent_stall;
    logic dir_in;
  } ep0_flags_t;

  // a host data/status token must be refused
  function automatic logic must_stall(ep0_stage_t st, ep0_flags_t f, logic is_out);
    return (st == ST_STALLED) || f.send_stall || (is_out && f.data_end);
  endfunction

  // a token that is not refused is accepted in these stage/flag combinations
  function automatic logic can_accept(ep0_stage_t st, ep0_flags_t f,
                                      logic is_out, logic is_in, logic is_status);
    case (st)
      ST_RX:     return is_out && !f.rx_ready;
      ST_TX:     return is_in && f.tx_ready;
      ST_STATUS: return is_status;
      default:   return 1'b0;
    endcase
  endfunction

  // stage entered when the CPU services a setup packet
  function automatic ep0_stage_t after_service(logic dend, logic dir_in);
    if (dend)   return ST_STATUS;
    if (dir_in) return ST_TX;
    return ST_RX;
  endfunction
endpackage

// File: rtl/ep0_bus_resp.sv
module ep0_bus_resp
  import ep0_pkg::*;
(
  input  ep0_stage_t stage_q,
  input  ep0_flags_t flags_q,
  input  logic       tok_setup,
  input  logic       tok_out,
  input  logic       tok_in,
  input  logic       tok_status,
  output logic       ev_setup,
  output logic       ev_ack_out,
  output logic       ev_ack_in,
  output logic       ev_ack_status,
  output logic       ev_stall,
  output logic       ev_nak,
  output ep0_hs_t    hs_next
);
  logic is_out, is_in, is_status, data_tok, refuse, accept;

  // priority among simultaneous tokens: setup, out, in, status
  assign is_out    = tok_out & ~tok_setup;
  assign is_in     = tok_in & ~tok_setup & ~tok_out;
  assign is_status = tok_status & ~tok_setup & ~tok_out & ~tok_in;
  assign data_tok  = is_out | is_in | is_status;

  assign refuse = data_tok & must_stall(stage_q, flags_q, is_out);
  assign accept = data_tok & ~refuse &
                  can_accept(stage_q, flags_q, is_out, is_in, is_status);

  assign ev_setup      = tok_setup;
  assign ev_stall      = refuse;
  assign ev_ack_out    = accept & is_out;
  assign ev_ack_in     = accept & is_in;
  assign ev_ack_status = accept & is_status;
  assign ev_nak        = data_tok & ~refuse & ~accept;

  always_comb begin
    if (ev_setup)      hs_next = HS_ACK;
    else if (ev_stall) hs_next = HS_STALL;
    else if (accept)   hs_next = HS_ACK;
    else if (ev_nak)   hs_next = HS_NAK;
    else               hs_next = HS_NONE;
  end
endmodule

// File: rtl/ep0_flag_regs.sv
module ep0_flag_regs
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_setup,
  input  logic       setup_dir_in,
  input  logic       ev_ack_out,
  input  logic       ev_ack_in,
  input  logic       ev_ack_status,
  input  logic       ev_stall,
  input  logic       wr_svc,
  input  logic       wr_txr,
  input  logic       wr_dend,
  input  logic       wr_sstall,
  input  logic       wr_clr_sent,
  output ep0_flags_t flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (ev_setup) begin
        flags_q.rx_ready   <= 1'b1;
        flags_q.tx_ready   <= 1'b0;
        flags_q.data_end   <= 1'b0;
        flags_q.send_stall <= 1'b0;
        flags_q.dir_in     <= setup_dir_in;
      end else begin
        if (ev_ack_out)          flags_q.rx_ready <= 1'b1;
        else if (wr_svc)         flags_q.rx_ready <= 1'b0;

        if (ev_ack_in | ev_stall) flags_q.tx_ready <= 1'b0;
        else if (wr_txr)          flags_q.tx_ready <= 1'b1;

        if (ev_ack_status)       flags_q.data_end <= 1'b0;
        else if (wr_dend)        flags_q.data_end <= 1'b1;

        if (ev_stall)            flags_q.send_stall <= 1'b0;
        else if (wr_sstall)      flags_q.send_stall <= 1'b1;
      end

      if (ev_stall)              flags_q.sent_stall <= 1'b1;
      else if (wr_clr_sent)      flags_q.sent_stall <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ep0_flags_t flags_q,
  input  logic       ev_setup,
  input  logic       ev_ack_in,
  input  logic       ev_ack_status,
  input  logic       ev_stall,
  input  logic       wr_svc,
  input  logic       wr_dend,
  input  logic       wr_sstall,
  output ep0_stage_t stage_q
);
  ep0_stage_t stage_d;

  always_comb begin
    stage_d = stage_q;
    if (ev_setup)
      stage_d = ST_IDLE;
    else if (ev_stall)
      stage_d = ST_STALLED;
    else if (ev_ack_status)
      stage_d = ST_IDLE;
    else if (ev_ack_in && flags_q.data_end)
      stage_d = ST_STATUS;
    else if (wr_sstall)
      stage_d = ST_STALLED;
    else if (stage_q == ST_IDLE && wr_svc && flags_q.rx_ready)
      stage_d = after_service(wr_dend, flags_q.dir_in);
    else if (stage_q == ST_RX && wr_svc && wr_dend)
      stage_d = ST_STATUS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_IDLE;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_event,
  input  logic cpu_rd,
  output logic irq_pulse,
  output logic irq_pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      irq_pulse   <= irq_event;
      irq_pending <= irq_event | (irq_pending & ~cpu_rd);
    end
  end
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_setup,
  input  logic            tok_setup_dir_in,
  input  logic            tok_out,
  input  logic            tok_in,
  input  logic            tok_status,
  output logic            hs_valid,
  output logic [HS_W-1:0] hs_code,
  input  logic            cpu_wr,
  input  logic            cpu_svc,
  input  logic            cpu_txr,
  input  logic            cpu_dend,
  input  logic            cpu_sstall,
  input  logic            cpu_clr_sent,
  input  logic            cpu_rd,
  output logic            rx_ready,
  output logic            tx_ready,
  output logic            data_end,
  output logic            send_stall,
  output logic            sent_stall,
  output logic [ST_W-1:0] stage,
  output logic            irq_pulse,
  output logic            irq_pending
);
  ep0_flags_t flags_q;
  ep0_stage_t stage_q;
  ep0_hs_t    hs_next;

  // named internal events, visible to the bound checker
  logic ev_setup, ev_ack_out, ev_ack_in, ev_ack_status, ev_stall, ev_nak;
  logic wr_ok, wr_svc, wr_txr, wr_dend, wr_sstall, wr_clr_sent;
  logic irq_event;

  // a setup token overrides a CPU write in the same cycle
  assign wr_ok       = cpu_wr & ~tok_setup;
  assign wr_svc      = wr_ok & cpu_svc;
  assign wr_txr      = wr_ok & cpu_txr;
  assign wr_dend     = wr_ok & cpu_dend;
  assign wr_sstall   = wr_ok & cpu_sstall;
  assign wr_clr_sent = wr_ok & cpu_clr_sent;

  ep0_bus_resp u_resp (
    .stage_q       (stage_q),
    .flags_q       (flags_q),
    .tok_setup     (tok_setup),
    .tok_out       (tok_out),
    .tok_in        (tok_in),
    .tok_status    (tok_status),
    .ev_setup      (ev_setup),
    .ev_ack_out    (ev_ack_out),
    .ev_ack_in     (ev_ack_in),
    .ev_ack_status (ev_ack_status),
    .ev_stall      (ev_stall),
    .ev_nak        (ev_nak),
    .hs_next       (hs_next)
  );

  ep0_flag_regs u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_setup      (ev_setup),
    .setup_dir_in  (tok_setup_dir_in),
    .ev_ack_out    (ev_ack_out),
    .ev_ack_in     (ev_ack_in),
    .ev_ack_status (ev_ack_status),
    .ev_stall      (ev_stall),
    .wr_svc        (wr_svc),
    .wr_txr        (wr_txr),
    .wr_dend       (wr_dend),
    .wr_sstall     (wr_sstall),
    .wr_clr_sent   (wr_clr_sent),
    .flags_q       (flags_q)
  );

  ep0_stage_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags_q       (flags_q),
    .ev_setup      (ev_setup),
    .ev_ack_in     (ev_ack_in),
    .ev_ack_status (ev_ack_status),
    .ev_stall      (ev_stall),
    .wr_svc        (wr_svc),
    .wr_dend       (wr_dend),
    .wr_sstall     (wr_sstall),
    .stage_q       (stage_q)
  );

  assign irq_event = ev_setup | ev_ack_out | ev_ack_in | ev_ack_status | ev_stall;

  ep0_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_event   (irq_event),
    .cpu_rd      (cpu_rd),
    .irq_pulse   (irq_pulse),
    .irq_pending (irq_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= (hs_next != HS_NONE);
      hs_code  <= hs_next;
    end
  end

  assign rx_ready   = flags_q.rx_ready;
  assign tx_ready   = flags_q.tx_ready;
  assign data_end   = flags_q.data_end;
  assign send_stall = flags_q.send_stall;
  assign sent_stall = flags_q.sent_stall;
  assign stage      = stage_q;
endmodule

// File: rtl/ep0_ctrl_seq_chk.sv
module ep0_ctrl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_setup,
  input logic       tok_out,
  input logic       tok_in,
  input logic       tok_status,
  input logic       cpu_wr,
  input logic       cpu_clr_sent,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       rx_ready,
  input logic       tx_ready,
  input logic       send_stall,
  input logic       sent_stall,
  input logic [2:0] stage,
  input logic       irq_pulse,
  input logic       irq_pending,
  input logic       ev_stall,
  input logic       ev_nak
);
  logic any_tok;
  assign any_tok = tok_setup | tok_out | tok_in | tok_status;

  a_r12_hs_follows_token: assert property (@(posedge clk) disable iff (!rst_n)
    any_tok |=> hs_valid);
  a_r12_no_spurious_hs: assert property (@(posedge clk) disable iff (!rst_n)
    !any_tok |=> !hs_valid);
  a_r2_setup_response: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (hs_code == 2'd1) && rx_ready && (stage == 3'd0));
  a_r8_stall_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd3) |-> sent_stall && !send_stall && !tx_ready && (stage == 3'd4));
  a_r8_stall_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> irq_pulse && sent_stall);
  a_r11_nak_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak |=> !irq_pulse);
  a_r11_pending_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_pending);
  a_r10_sent_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_stall && !(cpu_wr && cpu_clr_sent && !tok_setup)) |=> sent_stall);
  a_r1_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= 3'd4);
endmodule

bind ep0_ctrl_seq ep0_ctrl_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tok_setup    (tok_setup),
  .tok_out      (tok_out),
  .tok_in       (tok_in),
  .tok_status   (tok_status),
  .cpu_wr       (cpu_wr),
  .cpu_clr_sent (cpu_clr_sent),
  .hs_valid     (hs_valid),
  .hs_code      (hs_code),
  .rx_ready     (rx_ready),
  .tx_ready     (tx_ready),
  .send_stall   (send_stall),
  .sent_stall   (sent_stall),
  .stage        (stage),
  .irq_pulse    (irq_pulse),
  .irq_pending  (irq_pending),
  .ev_stall     (ev_stall),
  .ev_nak       (ev_nak)
);

// File: tb/ep0_ctrl_seq_tb.sv
module ep0_ctrl_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_setup = 0, tok_setup_dir_in = 0, tok_out = 0, tok_in = 0, tok_status = 0;
  logic cpu_wr = 0, cpu_svc = 0, cpu_txr = 0, cpu_dend = 0, cpu_sstall = 0, cpu_clr_sent = 0, cpu_rd = 0;
  logic hs_valid, rx_ready, tx_ready, data_end, send_stall, sent_stall, irq_pulse, irq_pending;
  logic [1:0] hs_code;
  logic [2:0] stage;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [2:0] m_stage;
  logic m_rx, m_tx, m_de, m_ss, m_sent, m_dir, m_hv, m_irq, m_pend;
  logic [1:0] m_hs;

  always #4 clk = ~clk;

  ep0_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .tok_setup(tok_setup), .tok_setup_dir_in(tok_setup_dir_in),
    .tok_out(tok_out), .tok_in(tok_in), .tok_status(tok_status),
    .hs_valid(hs_valid), .hs_code(hs_code),
    .cpu_wr(cpu_wr), .cpu_svc(cpu_svc), .cpu_txr(cpu_txr), .cpu_dend(cpu_dend),
    .cpu_sstall(cpu_sstall), .cpu_clr_sent(cpu_clr_sent), .cpu_rd(cpu_rd),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .data_end(data_end),
    .send_stall(send_stall), .sent_stall(sent_stall), .stage(stage),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  function automatic logic [12:0] pack_obs(logic hv, logic [1:0] hs, logic rx, logic tx, logic de,
                                           logic ss, logic st, logic [2:0] sg, logic ip, logic pd);
    return {hv, hs, rx, tx, de, ss, st, sg, ip, pd};
  endfunction

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    check(tag,
          pack_obs(hs_valid, hs_code, rx_ready, tx_ready, data_end, send_stall, sent_stall,
                   stage, irq_pulse, irq_pending),
          pack_obs(m_hv, m_hs, m_rx, m_tx, m_de, m_ss, m_sent, m_stage, m_irq, m_pend));
  endtask

  // model of one clock edge, derived from the requirements
  task automatic model_edge(logic su, logic dir, logic o, logic i, logic s,
                            logic w, logic svc, logic txr, logic dend, logic sst,
                            logic clr, logic rd);
    logic ev;
    ev = 0;
    m_hv = su | o | i | s;
    m_hs = 2'd0;
    if (su) begin                               // R2, R13
      m_hs = 2'd1; ev = 1;
      m_rx = 1; m_tx = 0; m_de = 0; m_ss = 0; m_dir = dir; m_stage = 3'd0;
    end else if (o | i | s) begin
      if (m_stage == 3'd4 || m_ss || (o && m_de)) begin   // R8, R9
        m_hs = 2'd3; ev = 1; m_sent = 1; m_ss = 0; m_tx = 0; m_stage = 3'd4;
      end else if (m_stage == 3'd1 && o && !m_rx) begin   // R6
        m_hs = 2'd1; ev = 1; m_rx = 1;
      end else if (m_stage == 3'd2 && i && m_tx) begin    // R4, R5
        m_hs = 2'd1; ev = 1; m_tx = 0;
        if (m_de) m_stage = 3'd3;
      end else if (m_stage == 3'd3 && s) begin            // R7
        m_hs = 2'd1; ev = 1; m_de = 0; m_stage = 3'd0;
      end else begin
        m_hs = 2'd2;                                      // R12
      end
    end else if (w) begin
      logic [2:0] ns;
      ns = m_stage;
      if (sst) ns = 3'd4;
      else if (m_stage == 3'd0 && svc && m_rx) ns = dend ? 3'd3 : (m_dir ? 3'd2 : 3'd1);
      else if (m_stage == 3'd1 && svc && dend) ns = 3'd3;
      m_stage = ns;
      if (svc) m_rx = 0;
      if (txr) m_tx = 1;
      if (dend) m_de = 1;
      if (sst) m_ss = 1;
      if (clr) m_sent = 0;
    end
    m_irq = ev;
    m_pend = ev | (m_pend & ~rd);               // R11
  endtask

  task automatic step(string tag, logic su, logic dir, logic o, logic i, logic s,
                      logic w, logic svc, logic txr, logic dend, logic sst,
                      logic clr, logic rd);
    tok_setup = su; tok_setup_dir_in = dir; tok_out = o; tok_in = i; tok_status = s;
    cpu_wr = w; cpu_svc = svc; cpu_txr = txr; cpu_dend = dend; cpu_sstall = sst;
    cpu_clr_sent = clr; cpu_rd = rd;
    @(posedge clk);
    model_edge(su, dir, o, i, s, w, svc, txr, dend, sst, clr, rd);
    @(negedge clk);
    tok_setup = 0; tok_out = 0; tok_in = 0; tok_status = 0;
    cpu_wr = 0; cpu_svc = 0; cpu_txr = 0; cpu_dend = 0; cpu_sstall = 0;
    cpu_clr_sent = 0; cpu_rd = 0;
    check_model(tag);
  endtask

  task automatic setup_tok(string tag, logic dir);
    step(tag, 1, dir, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic out_tok(string tag);    step(tag, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic in_tok(string tag);     step(tag, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic status_tok(string tag); step(tag, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic cpu_write(string tag, logic svc, logic txr, logic dend, logic sst, logic clr);
    step(tag, 0, 0, 0, 0, 0, 1, svc, txr, dend, sst, clr, 0);
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    check(tag, {12'd0, act}, {12'd0, exp});
  endtask

  task automatic expect_hs(string tag, logic [1:0] exp);
    check(tag, {10'd0, hs_valid, hs_code}, {10'd0, 1'b1, exp});
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stage = 0; m_rx = 0; m_tx = 0; m_de = 0; m_ss = 0; m_sent = 0; m_dir = 0;
    m_hv = 0; m_hs = 0; m_irq = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check_model("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_model("R1 after release");

    // IN request with two packets
    setup_tok("R2 setup in", 1);
    expect_hs("R2 setup ack", 2'd1);
    expect_bit("R11 setup irq", irq_pulse, 1'b1);
    cpu_write("R3 service in", 1, 0, 0, 0, 0);
    expect_bit("R3 rx cleared", rx_ready, 1'b0);
    check("R3 stage tx", {10'd0, stage}, {10'd0, 3'd2});
    in_tok("R4 in nak");
    expect_hs("R4 nak empty", 2'd2);
    expect_bit("R11 no irq on nak", irq_pulse, 1'b0);
    cpu_write("R4 queue", 0, 1, 0, 0, 0);
    in_tok("R4 in ack");
    expect_hs("R4 ack", 2'd1);
    cpu_write("R5 queue last", 0, 1, 1, 0, 0);
    in_tok("R5 last in");
    check("R5 stage status", {10'd0, stage}, {10'd0, 3'd3});
    step("R11 read clears", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    expect_bit("R11 pending cleared", irq_pending, 1'b0);
    status_tok("R7 status ack");
    expect_hs("R7 ack", 2'd1);
    check("R7 back idle", {10'd0, stage}, {10'd0, 3'd0});
    status_tok("R7 status nak idle");
    expect_hs("R7 nak in idle", 2'd2);

    // OUT request, then host overrun
    setup_tok("R2 setup out", 0);
    cpu_write("R3 service out", 1, 0, 0, 0, 0);
    check("R3 stage rx", {10'd0, stage}, {10'd0, 3'd1});
    out_tok("R6 out ack");
    expect_hs("R6 ack", 2'd1);
    out_tok("R6 out nak");
    expect_hs("R6 nak full", 2'd2);
    cpu_write("R6 last service", 1, 0, 1, 0, 0);
    check("R6 stage status", {10'd0, stage}, {10'd0, 3'd3});
    out_tok("R9 overrun");
    expect_hs("R9 stall", 2'd3);
    expect_bit("R9 sent set", sent_stall, 1'b1);
    step("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_bit("R10 still set", sent_stall, 1'b1);
    cpu_write("R10 clear", 0, 0, 0, 0, 1);
    expect_bit("R10 cleared", sent_stall, 1'b0);

    // CPU-requested stall
    setup_tok("R2 setup leaves stall", 1);
    cpu_write("R8 request stall", 0, 0, 0, 1, 0);
    check("R8 stage stalled", {10'd0, stage}, {10'd0, 3'd4});
    in_tok("R8 in stalled");
    expect_hs("R8 stall", 2'd3);
    expect_bit("R8 send cleared", send_stall, 1'b0);
    status_tok("R8 status stalled");
    expect_hs("R8 still stall", 2'd3);

    // setup in same cycle as a write
    step("R13 setup over write", 1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0);
    expect_bit("R13 rx kept", rx_ready, 1'b1);
    expect_bit("R13 sent kept", sent_stall, 1'b1);
    check("R13 stage idle", {10'd0, stage}, {10'd0, 3'd0});

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic rd;
      r = $urandom % 100;
      rd = ($urandom % 3) == 0;
      if (r < 10)
        step("R2 random setup", 1, 1'($urandom % 2), 0, 0, 0, 0, 0, 0, 0, 0, 0, rd);
      else if (r < 30)
        step("R6 R9 random out", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, rd);
      else if (r < 50)
        step("R4 R5 random in", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, rd);
      else if (r < 60)
        step("R7 random status", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, rd);
      else if (r < 92)
        step("R3 R8 R10 random write", 0, 0, 0, 0, 0, 1,
             1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 4) == 0),
             1'(($urandom % 20) == 0), 1'(($urandom % 4) == 0), rd);
      else
        step("R11 R12 random idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rd);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule